// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Stuff-Bit Removal

This block sits behind the synchroniser of a CAN receive line and turns the raw line level into a stream of frame bits. While idle it watches for the first dominant (logic 0) level. That clock cycle becomes the timing reference for the whole frame. From then on it samples the line once per nominal bit time, at a fixed fraction of the bit. Stuff bits are recognised from the recent raw history and dropped. Every remaining bit is handed to the downstream field parser with a one-cycle strobe and its index within the frame.

The parser drives two control levels back into the block. The first switches stuff removal off once the parser reaches the CRC delimiter, because no stuffing is applied from that point on. The second ends the frame and returns the block to idle. Bit timing is an integer count of clocks set by parameter. A phase counter wraps every bit, so sample instants never drift over a frame.

The output is a stream that carries only a valid strobe. The bus cannot be paused, so the block offers no ready input and accepts no back-pressure. A bit is presented for exactly one cycle, and the parser must take it in that cycle.

Top module: `can_bit_destuffer`

## Requirements
- R1: While idle with a recessive (1) line, `bit_valid` stays low. The first clock edge that sees `rx_sync` at 0 becomes the frame reference edge.
- R2: With BT = `CLK_PER_BIT` and OFS = floor(BT*`SAMPLE_PCT`/100), raw bit n is the value of `rx_sync` at reference edge + n*BT + OFS. Its result appears on the outputs in the cycle after that edge.
- R3: Each raw bit that is not a stuff bit raises `bit_valid` for exactly one cycle. It carries the sampled level on `bit_value` and a frame index on `bit_index`. The index starts at 0 and rises by one per delivered bit only.
- R4: A raw bit is a stuff bit, and is not delivered, when at least six raw bits have been sampled in this frame and the last six, the current one included and oldest first, read 000001 or 111110.
- R5: Stuff bits stay in the raw history, so a run of five that begins with a stuff bit makes the following opposite bit a stuff bit.
- R6: While `destuff_off` is 1, no raw bit is treated as a stuff bit, and every sampled bit is delivered.
- R7: `sof_pulse` is high together with the strobe of frame bit 0. `sof_err` is high in that same cycle when bit 0 was sampled recessive (1).
- R8: When `frame_end` is 1 at a clock edge, the outputs are low after that edge. The phase, index and history are cleared, and the block is idle. The next dominant level starts a new frame at index 0.
- R9: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sync | input | 1 | Synchronised CAN receive level, 0 = dominant |
| destuff_off | input | 1 | From the parser: stop stuff removal (CRC delimiter reached) |
| frame_end | input | 1 | From the parser: frame finished, return to idle |
| bit_valid | output | 1 | One-cycle strobe for a delivered frame bit |
| bit_value | output | 1 | Sampled level of the delivered bit |
| bit_index | output | IDX_W | Frame-bit index of the delivered bit, stuff bits not counted |
| sof_pulse | output | 1 | High with the strobe of frame bit 0 |
| sof_err | output | 1 | High with the strobe of frame bit 0 when it was recessive |

## Verification
Every result of this block is due one cycle after its sample edge. For raw bit n, that is reference edge + n*BT + OFS + 1. After a `frame_end` edge, idle outputs are due in the next cycle. The bench records the reference edge itself by dropping the line on a falling clock edge. It then walks through every cycle of the frame. On each falling edge it compares `bit_valid` with the slot computed from its own stuffing encoder, so a strobe one cycle early or late counts as a mismatch. Value, index and the start-of-frame flags are compared only in the cycles where a strobe is due.

// File: rtl/can_samp_pkg.sv
`timescale 1ns/1ps
package can_samp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } samp_state_t;

  // raw bits that must precede a bit before the stuff rule applies
  localparam int STUFF_RUN = 5;
endpackage

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer #(
  parameter int BIT_CLKS = 50,
  parameter int SAMP_OFS = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic sample_tick
);
  localparam int PH_W = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(BIT_CLKS - 1);
  localparam logic [PH_W-1:0] PH_SAMP  = PH_W'(SAMP_OFS);
  localparam logic [PH_W-1:0] PH_FIRST = PH_W'(1);

  logic [PH_W-1:0] phase;
  logic            running;

  // phase equals (edge - reference edge) mod BIT_CLKS while running
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      phase   <= '0;
      running <= 1'b0;
    end else if (start) begin
      phase   <= PH_FIRST;
      running <= 1'b1;
    end else if (running) begin
      phase <= (phase == PH_LAST) ? '0 : phase + PH_FIRST;
    end
  end

  assign sample_tick = running && (phase == PH_SAMP);
endmodule

// File: rtl/can_stuff_window.sv
`timescale 1ns/1ps
module can_stuff_window
  import can_samp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic shift,
  input  logic raw_bit,
  input  logic enable,
  output logic is_stuff
);
  localparam int CNT_W = $clog2(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STUFF_RUN);

  logic [STUFF_RUN-1:0] hist;      // previous raw bits, newest in bit 0
  logic [CNT_W-1:0]     raw_seen;  // raw bits sampled so far, saturating
  logic [STUFF_RUN:0]   window;

  assign window = {hist, raw_bit};

  always_comb begin
    is_stuff = 1'b0;
    if (enable && raw_seen == CNT_FULL) begin
      is_stuff = (window == {{STUFF_RUN{1'b0}}, 1'b1}) ||
                 (window == {{STUFF_RUN{1'b1}}, 1'b0});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hist     <= '0;
      raw_seen <= '0;
    end else if (shift) begin
      hist <= {hist[STUFF_RUN-2:0], raw_bit};
      if (raw_seen != CNT_FULL) raw_seen <= raw_seen + CNT_W'(1);
    end
  end
endmodule

// File: rtl/can_bit_destuffer.sv
`timescale 1ns/1ps
module can_bit_destuffer
  import can_samp_pkg::*;
#(
  parameter int CLK_PER_BIT = 50,
  parameter int SAMPLE_PCT  = 70,
  parameter int IDX_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_sync,
  input  logic             destuff_off,
  input  logic             frame_end,
  output logic             bit_valid,
  output logic             bit_value,
  output logic [IDX_W-1:0] bit_index,
  output logic             sof_pulse,
  output logic             sof_err
);
  localparam int OFS_RAW = (CLK_PER_BIT * SAMPLE_PCT) / 100;
  localparam int OFS_EFF = (OFS_RAW < 1) ? 1 :
                           (OFS_RAW > CLK_PER_BIT - 1) ? CLK_PER_BIT - 1 : OFS_RAW;

  samp_state_t      state;
  logic [IDX_W-1:0] idx_cnt;
  logic             start;
  logic             tick;
  logic             stuff_hit;

  assign start = (state == ST_IDLE) && !rx_sync && !frame_end;

  can_bit_timer #(
    .BIT_CLKS (CLK_PER_BIT),
    .SAMP_OFS (OFS_EFF)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .clear       (frame_end),
    .sample_tick (tick)
  );

  can_stuff_window u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (frame_end || start),
    .shift    (tick && !frame_end),
    .raw_bit  (rx_sync),
    .enable   (!destuff_off),
    .is_stuff (stuff_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || frame_end) begin
      state     <= ST_IDLE;
      idx_cnt   <= '0;
      bit_valid <= 1'b0;
      bit_value <= 1'b0;
      bit_index <= '0;
      sof_pulse <= 1'b0;
      sof_err   <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      sof_pulse <= 1'b0;
      sof_err   <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= ST_RUN;
        ST_RUN: begin
          if (tick && !stuff_hit) begin
            bit_valid <= 1'b1;
            bit_value <= rx_sync;
            bit_index <= idx_cnt;
            sof_pulse <= (idx_cnt == '0);
            sof_err   <= (idx_cnt == '0) && rx_sync;
            idx_cnt   <= idx_cnt + IDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/can_bit_destuffer_chk.sv
`timescale 1ns/1ps
module can_bit_destuffer_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_end,
  input logic             bit_valid,
  input logic             bit_value,
  input logic [IDX_W-1:0] bit_index,
  input logic             sof_pulse,
  input logic             sof_err
);
  logic [IDX_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) last_idx <= '0;
    else if (bit_valid) last_idx <= bit_index;
  end

  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid); // R3
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !sof_pulse) |-> (bit_index == IDX_W'(last_idx + IDX_W'(1)))); // R3
  AST_SOF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> (bit_valid && bit_index == '0)); // R7
  AST_SOF_ERR_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sof_err |-> (sof_pulse && bit_value)); // R7
  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!bit_valid && !sof_pulse)); // R8
endmodule

bind can_bit_destuffer can_bit_destuffer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_end (frame_end),
  .bit_valid (bit_valid),
  .bit_value (bit_value),
  .bit_index (bit_index),
  .sof_pulse (sof_pulse),
  .sof_err   (sof_err)
);

// File: tb/can_bit_destuffer_bench.sv
`timescale 1ns/1ps
module can_bit_destuffer_bench;
  localparam int BT  = 10;
  localparam int PCT = 70;
  localparam int OFS = BT * PCT / 100;
  localparam int IW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_sync = 1'b1;
  logic          destuff_off = 1'b0;
  logic          frame_end = 1'b0;
  logic          bit_valid, bit_value, sof_pulse, sof_err;
  logic [IW-1:0] bit_index;

  always #2 clk = ~clk;

  can_bit_destuffer #(.CLK_PER_BIT(BT), .SAMPLE_PCT(PCT), .IDX_W(IW)) u_can_bit_destuffer (
    .clk(clk), .rst_n(rst_n), .rx_sync(rx_sync), .destuff_off(destuff_off),
    .frame_end(frame_end), .bit_valid(bit_valid), .bit_value(bit_value),
    .bit_index(bit_index), .sof_pulse(sof_pulse), .sof_err(sof_err));

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;
  logic fb   [256];
  logic raw  [512];
  logic rstf [512];
  int   nfb, nraw;
  logic [15:0] lfsr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic mk_frame(input int kind, input int len);
    nfb = len;
    fb[0] = 1'b0;
    for (int i = 1; i < len; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (kind)
        0: fb[i] = 1'b0;
        1: fb[i] = 1'b1;
        2: fb[i] = i[0];
        3: fb[i] = lfsr[0];
        4: fb[i] = (i <= 5) ? 1'b1 : ((i <= 9) ? 1'b0 : lfsr[0]); // R5 pattern
        default: fb[i] = ((i / 6) % 2) == 1;
      endcase
    end
  endtask

  // independent stuffing encoder: stuff only ahead of frame bits below d
  task automatic encode(input int d);
    nraw = 0;
    for (int k = 0; k < nfb; k++) begin
      if (k < d && nraw >= 5 && raw[nraw-1] == raw[nraw-2] && raw[nraw-1] == raw[nraw-3] &&
          raw[nraw-1] == raw[nraw-4] && raw[nraw-1] == raw[nraw-5]) begin
        raw[nraw] = ~raw[nraw-1];
        rstf[nraw] = 1'b1;
        nraw++;
      end
      raw[nraw] = fb[k];
      rstf[nraw] = 1'b0;
      nraw++;
    end
  endtask

  task automatic end_frame();
    @(negedge clk);
    frame_end = 1'b1;
    rx_sync = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    destuff_off = 1'b0;
    chk(bit_valid == 1'b0 && sof_pulse == 1'b0, "R8", bit_valid, 0);
  endtask

  task automatic run_frame(input int d, input int stop_j);
    int  kdel = 0;
    int  last = nraw * BT + 1;
    bit  evd;
    if (stop_j < last) last = stop_j;
    for (int j = 0; j < last; j++) begin
      @(negedge clk);
      if (j > 0) begin
        int jj = j - 1;
        evd = (jj % BT == OFS) && !rstf[jj / BT];
        chk(bit_valid == evd, rstf[jj / BT] ? "R4" : "R2", bit_valid, evd);
        if (evd && bit_valid) begin
          chk(bit_value == fb[kdel], (kdel >= d) ? "R6" : (kdel >= 6 && kdel <= 10) ? "R5" : "R3",
              bit_value, fb[kdel]);
          chk(bit_index == IW'(kdel), "R3", bit_index, kdel);
          chk(sof_pulse == (kdel == 0), "R7", sof_pulse, kdel == 0);
          chk(sof_err == 1'b0, "R7", sof_err, 0);
          if (kdel == d - 1) destuff_off = 1'b1;
          kdel++;
        end
      end
      rx_sync = (j < nraw * BT) ? raw[j / BT] : 1'b1;
    end
    if (stop_j >= nraw * BT + 1) chk(kdel == nfb, "R3", kdel, nfb);
    end_frame();
  endtask

  task automatic idle_quiet(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(bit_valid == 1'b0, req, bit_valid, 0);
    end
  endtask

  initial begin
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk(bit_valid == 0 && sof_pulse == 0 && sof_err == 0 && bit_index == 0, "R9",
        {bit_valid, sof_pulse, sof_err}, 0);
    rst_n = 1'b1;
    idle_quiet(3 * BT, "R1");

    // sweep of bit patterns, with and without the stuff-off point
    for (int kind = 0; kind < 6; kind++) begin
      for (int dsel = 0; dsel < 2; dsel++) begin
        int d = (dsel == 0) ? 1000 : 12;
        mk_frame(kind, 30 + kind * 9);
        encode(d);
        run_frame(d, 1 << 30);
        idle_quiet(BT + 3, "R1");
      end
    end

    // recessive start-of-frame sample: short dominant glitch
    @(negedge clk);
    rx_sync = 1'b0;
    for (int j = 1; j <= OFS + 1; j++) begin
      @(negedge clk);
      if (j == 3) rx_sync = 1'b1;
      if (j == OFS + 1) begin
        chk(bit_valid == 1'b1 && bit_index == 0, "R7", bit_valid, 1);
        chk(sof_pulse == 1'b1, "R7", sof_pulse, 1);
        chk(sof_err == 1'b1 && bit_value == 1'b1, "R7", sof_err, 1);
      end
    end
    end_frame();
    idle_quiet(2 * BT, "R8");

    // abort mid-frame, then a fresh frame must restart at index 0
    mk_frame(3, 50);
    encode(1000);
    run_frame(1000, 20 * BT + 4);
    idle_quiet(3 * BT, "R8");
    mk_frame(0, 40);
    encode(1000);
    run_frame(1000, 1 << 30);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule